// File: doc/BRIEF.md
# Shared Clock Stabilization Divider

This block holds one long binary counter that serves two purposes in turn. After the external clock generator is enabled, the counter counts rising edges of the external clock as a start-up timer. The timer is short (16 edges) for a slow oscillator source and long (4096 edges) for a crystal. When the selected tap of the counter falls, a sticky status bit declares the external clock stable. From then on the same counter is clocked by the internal base clock and serves as the reference divider, with fixed taps feeding the external-reference and internal-reference outputs.

If the clock monitor is enabled and reports the external clock inactive, the status bit drops and the counter restarts from zero in timer mode. Because the taps then follow external-clock edges again, the reference ratios change. Software should therefore turn the monitor off after a loss, so that recovery is clean.

Both clock inputs are sampled by a fast system clock through synchronizers. Only rising edges are counted, and switching between the two sources is a change of which edge strobe advances the counter. No clock is gated, and no clock is muxed.

Top module: `clk_stab_divider`

## Requirements
- R1: While `gen_en` is low, the block is held in reset asynchronously: `ext_stable`, `stab_clk`, `eref_out`, `iref_out` and the internal count are all 0.
- R2: While `ext_stable` is 0, the counter advances by one on each rising edge of `ext_clk`. Edges of `base_clk` have no effect.
- R3: `stab_clk` equals count bit 3 when `xtal_sel` is 0, and count bit 11 when `xtal_sel` is 1. In short mode it is high after 8 external edges.
- R4: With `xtal_sel` at 0, `ext_stable` rises after the 16th external edge and is still 0 after the 15th.
- R5: With `xtal_sel` at 1, `ext_stable` rises after the 4096th external edge and is still 0 after the 4095th.
- R6: While `ext_stable` is 1, the counter advances only on rising edges of `base_clk`, and `ext_clk` edges have no effect. `eref_out` is count bit 5 and `iref_out` is count bit 9.
- R7: Once set, `ext_stable` stays 1 through later falling edges of `stab_clk`.
- R8: When `mon_en` and `ext_lost` are both 1 on a clock edge, `ext_stable` clears and the count returns to 0 on that edge. A fresh 16 or 4096 external edges sets it again.
- R9: `ext_lost` has no effect while `mon_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock for all state |
| gen_en | input | 1 | External generator enable; low is an asynchronous reset |
| xtal_sel | input | 1 | 1 selects the 4096-edge timer, 0 selects the 16-edge timer |
| mon_en | input | 1 | Clock monitor enable |
| ext_lost | input | 1 | Monitor reports the external clock inactive |
| ext_clk | input | 1 | External clock, slower than clk/4 |
| base_clk | input | 1 | Internal base clock, slower than clk/4 |
| stab_clk | output | 1 | Stabilization clock tap |
| ext_stable | output | 1 | Sticky external-clock-stable status |
| eref_out | output | 1 | External reference divider tap |
| iref_out | output | 1 | Internal reference divider tap |

## Verification
A counter that took edges from the wrong source shows up on `eref_out` within 32 edges, because the reference taps would keep moving when they should freeze. A counter that was not cleared on a loss shows up on the next recovery, because the status bit would rise before the full 16 edges. An off-by-one in the timer shows up within one edge of the 16 or 4096 boundary, about three sampling clocks after that edge. A status bit that is not sticky drops on the next tap fall, 16 base edges later.

// File: rtl/csd_pkg.sv
package csd_pkg;
   typedef enum logic {
      SRC_EXT  = 1'b0,
      SRC_BASE = 1'b1
   } csd_src_e;
endpackage

// File: rtl/csd_edge_sync.sv
module csd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("csd_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], async_in};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/csd_counter.sv
module csd_counter #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         step,
   output logic [W-1:0] count
);
   if (W < 4) begin : g_bad_width
      $error("csd_counter: W must be at least 4");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= '0;
      else if (step)  count <= count + 1'b1;
   end

   a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && step) |=> (count == $past(count) + 1'b1));
   a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0));
endmodule

// File: rtl/csd_stable_ctl.sv
module csd_stable_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic tap,
   input  logic lose,
   output logic stable
);
   logic tap_q;
   logic tap_fall;

   assign tap_fall = tap_q & ~tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_q  <= 1'b0;
         stable <= 1'b0;
      end else begin
         tap_q <= lose ? 1'b0 : tap;
         if (lose)          stable <= 1'b0;
         else if (tap_fall) stable <= 1'b1;
      end
   end

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stable && !lose) |=> stable);
endmodule

// File: rtl/clk_stab_divider.sv
module clk_stab_divider #(
   parameter int CNT_W       = 12,
   parameter int SHORT_TAP   = 3,
   parameter int LONG_TAP    = 11,
   parameter int EREF_TAP    = 5,
   parameter int IREF_TAP    = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic gen_en,
   input  logic xtal_sel,
   input  logic mon_en,
   input  logic ext_lost,
   input  logic ext_clk,
   input  logic base_clk,
   output logic stab_clk,
   output logic ext_stable,
   output logic eref_out,
   output logic iref_out
);
   import csd_pkg::*;

   localparam int MAX_TAP = CNT_W - 1;

   if (SHORT_TAP >= LONG_TAP || LONG_TAP > MAX_TAP) begin : g_bad_taps
      $error("clk_stab_divider: timer taps out of order or range");
   end
   if (EREF_TAP > MAX_TAP || IREF_TAP > MAX_TAP) begin : g_bad_refs
      $error("clk_stab_divider: reference tap out of range");
   end

   logic             ext_rise, base_rise, step, lose;
   logic [CNT_W-1:0] count;
   csd_src_e         src;

   csd_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk(clk), .rst_n(gen_en), .async_in(ext_clk), .rise(ext_rise));
   csd_edge_sync #(.STAGES(SYNC_STAGES)) u_base_sync (
      .clk(clk), .rst_n(gen_en), .async_in(base_clk), .rise(base_rise));

   assign src  = ext_stable ? SRC_BASE : SRC_EXT;
   assign step = (src == SRC_BASE) ? base_rise : ext_rise;
   assign lose = mon_en & ext_lost;

   csd_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(gen_en), .clear(lose), .step(step), .count(count));

   assign stab_clk = xtal_sel ? count[LONG_TAP] : count[SHORT_TAP];
   assign eref_out = count[EREF_TAP];
   assign iref_out = count[IREF_TAP];

   csd_stable_ctl u_ctl (
      .clk(clk), .rst_n(gen_en), .tap(stab_clk), .lose(lose), .stable(ext_stable));

   a_r4_set_on_fall: assert property (@(posedge clk) disable iff (!gen_en)
      $rose(ext_stable) |-> !stab_clk);
   a_r8_lost_clears: assert property (@(posedge clk) disable iff (!gen_en)
      (mon_en && ext_lost) |=> !ext_stable);
   a_r9_fall_cause: assert property (@(posedge clk) disable iff (!gen_en)
      $fell(ext_stable) |-> $past(mon_en && ext_lost));
   a_r2_base_ignored: assert property (@(posedge clk) disable iff (!gen_en)
      (!ext_stable && !ext_rise && !lose) |=> $stable(count));
endmodule

// File: tb/clk_stab_divider_test.sv
module clk_stab_divider_test;
   logic clk = 1'b0;
   logic gen_en = 1'b0, xtal_sel = 1'b0, mon_en = 1'b0, ext_lost = 1'b0;
   logic ext_clk = 1'b0, base_clk = 1'b0;
   logic stab_clk, ext_stable, eref_out, iref_out;
   int   n_run = 0, n_fail = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   clk_stab_divider uut (
      .clk(clk), .gen_en(gen_en), .xtal_sel(xtal_sel), .mon_en(mon_en),
      .ext_lost(ext_lost), .ext_clk(ext_clk), .base_clk(base_clk),
      .stab_clk(stab_clk), .ext_stable(ext_stable),
      .eref_out(eref_out), .iref_out(iref_out));

   task automatic check(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ext_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         ext_clk = 1'b1; idle(2); ext_clk = 1'b0; idle(2);
      end
      idle(6);
   endtask

   task automatic base_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         base_clk = 1'b1; idle(2); base_clk = 1'b0; idle(2);
      end
      idle(6);
   endtask

   task automatic restart(input logic long_mode);
      gen_en = 1'b0; idle(2);
      xtal_sel = long_mode;
      gen_en = 1'b1; idle(2);
   endtask

   initial begin
      idle(3);
      check("R1 stable in reset", ext_stable, 1'b0);
      check("R1 stab_clk in reset", stab_clk, 1'b0);
      check("R1 eref in reset", eref_out, 1'b0);
      gen_en = 1'b1; idle(2);
      // short mode: count 8 -> bit3 high
      ext_pulses(8);
      check("R3 stab_clk short at 8", stab_clk, 1'b1);
      ext_pulses(7);
      check("R4 not stable at 15", ext_stable, 1'b0);
      ext_pulses(1);
      check("R4 stable at 16", ext_stable, 1'b1);
      check("R3 stab_clk low at 16", stab_clk, 1'b0);
      // count 16 -> 32 on base edges
      base_pulses(16);
      check("R6 eref bit5 at 32", eref_out, 1'b1);
      check("R6 iref bit9 at 32", iref_out, 1'b0);
      check("R7 stays stable after tap fall", ext_stable, 1'b1);
      ext_pulses(32);
      check("R6 ext ignored when stable", eref_out, 1'b1);
      ext_lost = 1'b1; idle(3); ext_lost = 1'b0; idle(2);
      check("R9 lost ignored, monitor off", ext_stable, 1'b1);
      mon_en = 1'b1; ext_lost = 1'b1; idle(1); ext_lost = 1'b0; mon_en = 1'b0; idle(2);
      check("R8 lost clears stable", ext_stable, 1'b0);
      check("R8 lost clears count", eref_out, 1'b0);
      base_pulses(20);
      check("R2 base ignored stab_clk", stab_clk, 1'b0);
      check("R2 base ignored eref", eref_out, 1'b0);
      ext_pulses(15);
      check("R8 full restart at 15", ext_stable, 1'b0);
      ext_pulses(1);
      check("R8 recovers after 16", ext_stable, 1'b1);
      @(posedge clk); #3 gen_en = 1'b0; #1;
      check("R1 async clear", ext_stable, 1'b0);
      // long mode
      restart(1'b1);
      ext_pulses(16);
      check("R5 short tap unused in long mode", ext_stable, 1'b0);
      ext_pulses(4079);
      check("R5 not stable at 4095", ext_stable, 1'b0);
      check("R3 stab_clk long at 4095", stab_clk, 1'b1);
      check("R6 iref bit9 at 4095", iref_out, 1'b1);
      ext_pulses(1);
      check("R5 stable at 4096", ext_stable, 1'b1);
      check("R3 stab_clk long low at 4096", stab_clk, 1'b0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule